// File: doc/BRIEF.md
# Variable Rate Slot Request Generator

This codec-side block decides, once per 48 kHz link frame, which playback slots must carry a fresh sample from the controller in the following output frame. Each playback channel has a phase accumulator. At every frame start the accumulator adds the channel's programmed sample rate and is compared with the 48000 Hz link rate. A request is raised when the accumulator wraps, or when the channel's FIFO has fallen below a low-water mark. Requests are active-low flags that the input frame carries back to the controller.

When variable-rate operation is disabled, every active channel requests a sample in every frame, which gives fixed 48 kHz behaviour. Channels that are powered down, or that the build does not support, always drive their flag low. They take no data and their output tag is ignored. One frame after a request, the block looks at the slot's output tag. If the tag is set, the sample is pushed into the FIFO. If it is clear, a sticky underrun flag is raised for that channel.

The frame timing comes from a single `frame_start` strobe. The rate, FIFO level, power and tag inputs are sampled on that strobe.

Top module: `vrs_slotreq_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, all request flags read 0, and no push or underrun bit is set.
- R2: On a frame start with variable rate disabled, every supported, powered-up channel drives its flag to 0 (request), and its accumulator is cleared to 0.
- R3: On a frame start with variable rate enabled, a channel adds its rate to its accumulator. Its flag reads 0 (request) if the sum reaches 48000, in which case 48000 is subtracted, or if its FIFO level is below LOW_TH. Otherwise the flag reads 1. With the FIFO kept full, rates of 8000 and 44100 give exactly 8000 and 44100 requests over 48000 frames started from a cleared accumulator.
- R4: A programmed rate of 48000 or more is treated as 48000, so the channel requests in every frame: 48000 requests per 48000 frames.
- R5: A channel that is powered down (pwr_dn bit 1) or unsupported (SUPPORTED bit 0) drives its flag to 0. Its tag is ignored: no push and no underrun. Its accumulator is cleared.
- R6: On the frame start that follows a frame in which a powered-up, supported channel requested, a set tag bit produces a one-cycle push pulse for that channel. A set tag without a preceding request produces no push.
- R7: On that same frame start, a clear tag bit sets the channel's underrun bit. The bit stays set until reset.
- R8: Outputs change only on frame start cycles. On every other cycle the flags and underrun bits hold, and push is 0.
- R9: Re-enabling variable rate or powering up a channel restarts its phase from 0. At rate 24000 with a full FIFO, the first frame gives flag 1 and the second gives flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe at the start of each output frame |
| var_en | input | 1 | Variable-rate enable |
| rate_cfg | input | NCH*RATE_W | Per-channel sample rate in Hz, channel c at bits c*RATE_W |
| pwr_dn | input | NCH | Per-channel power-down, 1 = down |
| fifo_lvl | input | NCH*LVL_W | Per-channel FIFO fill level, channel c at bits c*LVL_W |
| tag_in | input | NCH | Output-frame tag bit of each channel's slot |
| slot_req_n | output | NCH | Active-low slot request flags |
| push | output | NCH | One-cycle pulse: the delivered sample is written to the FIFO |
| underrun | output | NCH | Sticky per-channel missing-sample flag |

## Verification
The long-run patterns hold the FIFO full and the tags set for 48000 frames. They distinguish a correct rate accumulator from one that wraps at the wrong bound, forgets the remainder, or skips the clamp above 48000. Directed sequences toggle the enable and the power-down bits and withhold tags. These separate the fixed-rate fallback, the phase restart, the masking and the sticky underrun from one another. Random frames mix in low FIFO levels, random tags and idle gaps between strobes, which exposes wrong threshold comparisons and outputs that move outside frame starts.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  localparam int unsigned LINK_RATE = 48000;

  function automatic int unsigned acc_width(input int unsigned rate_w);
    return ((rate_w > 16) ? rate_w : 16) + 1;
  endfunction
endpackage

// File: rtl/vrs_phase_acc.sv
module vrs_phase_acc #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              clear,
  input  logic [RATE_W-1:0] rate,
  output logic              ovf
);
  localparam int ACC_W = vrs_pkg::acc_width(RATE_W);
  localparam logic [ACC_W-1:0] LINK = ACC_W'(vrs_pkg::LINK_RATE);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] eff;
  logic [ACC_W-1:0] sum;

  always_comb begin
    eff = (ACC_W'(rate) > LINK) ? LINK : ACC_W'(rate);
    sum = acc_q + eff;
    ovf = (sum >= LINK);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_q <= '0;
    end else if (step) begin
      acc_q <= ovf ? (sum - LINK) : sum;
    end
  end
endmodule

// File: rtl/vrs_chan.sv
module vrs_chan #(
  parameter int   RATE_W = 16,
  parameter int   LVL_W  = 5,
  parameter int   LOW_TH = 4,
  parameter logic SUP    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              var_en,
  input  logic [RATE_W-1:0] rate,
  input  logic              pwr_dn,
  input  logic [LVL_W-1:0]  fifo_lvl,
  input  logic              tag,
  output logic              req_n,
  output logic              push,
  output logic              underrun
);
  logic active, run, ovf, wants, pend_q;

  assign active = SUP && !pwr_dn;
  assign run    = var_en && active;

  vrs_phase_acc #(.RATE_W(RATE_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .step  (frame_start && run),
    .clear (frame_start && !run),
    .rate  (rate),
    .ovf   (ovf)
  );

  assign wants = ovf || (fifo_lvl < LVL_W'(LOW_TH));

  always_ff @(posedge clk) begin
    if (rst) begin
      req_n    <= 1'b0;
      pend_q   <= 1'b0;
      push     <= 1'b0;
      underrun <= 1'b0;
    end else begin
      push <= 1'b0;
      if (frame_start) begin
        if (active && pend_q) begin
          if (tag) push     <= 1'b1;
          else     underrun <= 1'b1;
        end
        if (!active) begin
          req_n  <= 1'b0;
          pend_q <= 1'b0;
        end else if (!var_en) begin
          req_n  <= 1'b0;
          pend_q <= 1'b1;
        end else begin
          req_n  <= !wants;
          pend_q <= wants;
        end
      end
    end
  end
endmodule

// File: rtl/vrs_slotreq_gen.sv
module vrs_slotreq_gen #(
  parameter int             NCH       = 2,
  parameter int             RATE_W    = 16,
  parameter int             LVL_W     = 5,
  parameter int             LOW_TH    = 4,
  parameter logic [NCH-1:0] SUPPORTED = '1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_start,
  input  logic                  var_en,
  input  logic [NCH*RATE_W-1:0] rate_cfg,
  input  logic [NCH-1:0]        pwr_dn,
  input  logic [NCH*LVL_W-1:0]  fifo_lvl,
  input  logic [NCH-1:0]        tag_in,
  output logic [NCH-1:0]        slot_req_n,
  output logic [NCH-1:0]        push,
  output logic [NCH-1:0]        underrun
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    vrs_chan #(
      .RATE_W (RATE_W),
      .LVL_W  (LVL_W),
      .LOW_TH (LOW_TH),
      .SUP    (SUPPORTED[c])
    ) u_ch (
      .clk         (clk),
      .rst         (rst),
      .frame_start (frame_start),
      .var_en      (var_en),
      .rate        (rate_cfg[c*RATE_W +: RATE_W]),
      .pwr_dn      (pwr_dn[c]),
      .fifo_lvl    (fifo_lvl[c*LVL_W +: LVL_W]),
      .tag         (tag_in[c]),
      .req_n       (slot_req_n[c]),
      .push        (push[c]),
      .underrun    (underrun[c])
    );
  end
endmodule

// File: rtl/vrs_slotreq_chk.sv
module vrs_slotreq_chk #(
  parameter int             NCH       = 2,
  parameter logic [NCH-1:0] SUPPORTED = '1
) (
  input logic           clk,
  input logic           rst,
  input logic           frame_start,
  input logic           var_en,
  input logic [NCH-1:0] pwr_dn,
  input logic [NCH-1:0] tag_in,
  input logic [NCH-1:0] slot_req_n,
  input logic [NCH-1:0] push,
  input logic [NCH-1:0] underrun
);
  assert_fixed_rate_all_req_R2: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !var_en) |=> (slot_req_n == '0));

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (((slot_req_n | push) & ($past(pwr_dn) | ~SUPPORTED)) == '0));

  assert_push_needs_tag_R6: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> ((push & ~$past(tag_in)) == '0));

  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(underrun) & ~underrun) == '0));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> ($stable(slot_req_n) && (push == '0) && $stable(underrun)));
endmodule

bind vrs_slotreq_gen vrs_slotreq_chk #(.NCH(NCH), .SUPPORTED(SUPPORTED)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_start (frame_start),
  .var_en      (var_en),
  .pwr_dn      (pwr_dn),
  .tag_in      (tag_in),
  .slot_req_n  (slot_req_n),
  .push        (push),
  .underrun    (underrun)
);

// File: tb/tb_vrs_slotreq_gen.sv
module tb_vrs_slotreq_gen;
  localparam int CLK_P = 10;
  localparam int NCH = 3;
  localparam int RW = 16;
  localparam int LW = 5;
  localparam int LT = 4;
  localparam logic [NCH-1:0] SUP = 3'b011;

  logic clk = 0, rst = 1, frame_start = 0, var_en = 0;
  logic [NCH*RW-1:0] rate_cfg;
  logic [NCH*LW-1:0] fifo_lvl;
  logic [NCH-1:0] pwr_dn = '0, tag_in = '0, slot_req_n, push, underrun;
  logic [RW-1:0] r_in [NCH];
  logic [LW-1:0] f_in [NCH];

  int checks = 0, errors = 0;
  int m_acc [NCH];
  bit m_pend [NCH];
  bit m_under [NCH];
  logic [NCH-1:0] m_req = '0, m_push = '0;

  always #(CLK_P/2) clk = ~clk;

  always_comb
    for (int c = 0; c < NCH; c++) begin
      rate_cfg[c*RW +: RW] = r_in[c];
      fifo_lvl[c*LW +: LW] = f_in[c];
    end

  vrs_slotreq_gen #(.NCH(NCH), .RATE_W(RW), .LVL_W(LW), .LOW_TH(LT), .SUPPORTED(SUP)) dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .var_en(var_en),
    .rate_cfg(rate_cfg), .pwr_dn(pwr_dn), .fifo_lvl(fifo_lvl), .tag_in(tag_in),
    .slot_req_n(slot_req_n), .push(push), .underrun(underrun));

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic run_cycle(input bit fs);
    int s, eff;
    bit act, w;
    string tg;
    frame_start = fs;
    m_push = '0;
    if (fs) begin
      for (int c = 0; c < NCH; c++) begin
        act = SUP[c] && !pwr_dn[c];
        m_push[c] = act && m_pend[c] && tag_in[c];
        if (act && m_pend[c] && !tag_in[c]) m_under[c] = 1;
        if (!act) begin
          m_req[c] = 0; m_pend[c] = 0; m_acc[c] = 0;
        end else if (!var_en) begin
          m_req[c] = 0; m_pend[c] = 1; m_acc[c] = 0;
        end else begin
          eff = (r_in[c] > 48000) ? 48000 : int'(r_in[c]);
          s = m_acc[c] + eff;
          w = (s >= 48000);
          m_acc[c] = w ? s - 48000 : s;
          w = w || (f_in[c] < LW'(LT));
          m_req[c] = !w; m_pend[c] = w;
        end
      end
    end
    @(posedge clk); #1;
    for (int c = 0; c < NCH; c++) begin
      act = SUP[c] && !pwr_dn[c];
      tg = !fs ? "R8" : (!act ? "R5" : (!var_en ? "R2" : "R3"));
      chk(slot_req_n[c] == m_req[c], tg, $sformatf("req_n ch%0d", c), slot_req_n[c], m_req[c]);
      chk(push[c] == m_push[c], fs ? "R6" : "R8", $sformatf("push ch%0d", c), push[c], m_push[c]);
      chk(underrun[c] == m_under[c], fs ? "R7" : "R8", $sformatf("underrun ch%0d", c), underrun[c], m_under[c]);
    end
  endtask

  task automatic long_run(input int ra, input int rb, input string tg);
    int ca = 0, cb = 0;
    var_en = 0; tag_in = '1;
    run_cycle(1);
    var_en = 1; r_in[0] = RW'(ra); r_in[1] = RW'(rb);
    f_in[0] = '1; f_in[1] = '1;
    for (int i = 0; i < 48000; i++) begin
      run_cycle(1);
      if (!slot_req_n[0]) ca++;
      if (!slot_req_n[1]) cb++;
    end
    chk(ca == ((ra > 48000) ? 48000 : ra), tg, "long-run count ch0", ca, (ra > 48000) ? 48000 : ra);
    chk(cb == ((rb > 48000) ? 48000 : rb), tg, "long-run count ch1", cb, (rb > 48000) ? 48000 : rb);
  endtask

  initial begin
    #(CLK_P * 250000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pick;
    void'($urandom(32'd20240607));
    for (int c = 0; c < NCH; c++) begin
      r_in[c] = '0; f_in[c] = '0; m_acc[c] = 0; m_pend[c] = 0; m_under[c] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(slot_req_n == '0 && push == '0 && underrun == '0, "R1", "reset outputs",
        int'({slot_req_n, push, underrun}), 0);
    rst = 0;
    run_cycle(0);
    chk(slot_req_n == '0 && push == '0 && underrun == '0, "R1", "after reset",
        int'({slot_req_n, push, underrun}), 0);

    // R2: fixed-rate fallback, tags set so pushes follow
    tag_in = '1; f_in[0] = '1; f_in[1] = '1;
    repeat (3) run_cycle(1);
    chk(push[1:0] == 2'b11, "R6", "push in fixed rate", push[1:0], 3);

    // R9: phase restart at rate 24000
    var_en = 1; r_in[0] = 24000; r_in[1] = 24000;
    run_cycle(1);
    chk(slot_req_n[0] == 1'b1, "R9", "first frame after enable", slot_req_n[0], 1);
    run_cycle(1);
    chk(slot_req_n[0] == 1'b0, "R9", "second frame after enable", slot_req_n[0], 0);

    // R7: withheld tag after a request
    tag_in = 3'b110;
    run_cycle(1);
    chk(underrun[0] == 1'b1, "R7", "underrun set", underrun[0], 1);
    tag_in = '1;
    repeat (4) run_cycle(1);
    chk(underrun[0] == 1'b1, "R7", "underrun sticky", underrun[0], 1);

    // R5: powered-down channel ignores missing tag
    pwr_dn = 3'b010; tag_in = 3'b101;
    repeat (3) run_cycle(1);
    chk(slot_req_n[1] == 1'b0 && underrun[1] == 1'b0, "R5", "pd ch1 quiet",
        int'({slot_req_n[1], underrun[1]}), 0);
    pwr_dn = '0; tag_in = '1;

    // R3: low FIFO forces requests
    f_in[1] = LW'(LT - 1); r_in[1] = 0;
    run_cycle(1);
    chk(slot_req_n[1] == 1'b0, "R3", "low fifo request", slot_req_n[1], 0);
    f_in[1] = LW'(LT);
    run_cycle(1);
    chk(slot_req_n[1] == 1'b1, "R3", "fifo at threshold", slot_req_n[1], 1);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      var_en = ($urandom % 6) != 0;
      pwr_dn = (($urandom % 8) == 0) ? NCH'($urandom) : '0;
      tag_in = (($urandom % 5) == 0) ? NCH'($urandom) : '1;
      for (int c = 0; c < NCH; c++) begin
        pick = $urandom % 7;
        case (pick)
          0: r_in[c] = 8000;
          1: r_in[c] = 11025;
          2: r_in[c] = 22050;
          3: r_in[c] = 44100;
          4: r_in[c] = 48000;
          default: r_in[c] = RW'($urandom);
        endcase
        f_in[c] = LW'($urandom);
      end
      run_cycle(($urandom % 4) != 0);
    end

    // Long-run request counts
    pwr_dn = '0;
    long_run(8000, 44100, "R3");
    long_run(48000, 60000, "R4");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule